// File: doc/BRIEF.md
# Power Management Event Router

The router gathers power-management event pulses from around the chip and turns them into one of two interrupt requests: an active-low system management interrupt line or a level system control interrupt request. The events are address-trap hits from a parameterised number of devices, software writes of the sleep-enable bit, accesses to the microcontroller ports, and three SMBus events: a slave SMI message, the alert signal and a host-notify message. Every event sets a sticky status bit. Its enable bit, together with a routing select and a global SMI enable, decides whether it raises an interrupt and which one.

Software sees four words through a small register port. The control word holds the routing select, the global SMI enable, the interrupt-controller mode, the end-of-SMI strobe, the enables for sleep, microcontroller, SMBus and host-notify causes, and a three-bit code that picks the SCI interrupt number. The second word holds the per-device trap enables. The third holds the status bits, which are cleared by writing 1. Once an SMI is raised, the line stays low and further SMIs are held off until software strobes end-of-SMI.

Top module: `pm_event_router`

## Requirements
- R1: With the route bit (control bit 0) set, an enabled pending trap, sleep or microcontroller status drives `sci_req` high in the same cycle that the status bit becomes visible. No SMI is raised while the route bit is 1. With the route bit clear, enabled pending causes go to SMI instead and `sci_req` stays low.
- R2: No SMI is raised while the global SMI enable (control bit 1) is 0. An enabled status that is still pending when this bit is set raises an SMI one cycle later.
- R3: `smi_n` falls one cycle after an enabled status is visible. It then stays low, and no new SMI is raised, until control is written with bit 3 (end-of-SMI) set. `smi_n` is high in the cycle after that write. If an enabled status is still pending, `smi_n` is low again one cycle later.
- R4: A pulse on `trap_hit[i]` sets status bit i one cycle later, whatever the enable. It raises an interrupt only when trap-enable bit i (register 1) is set.
- R5: A `slp_wr_evt` pulse sets status bit N_TRAP (bit 4 by default). It raises an interrupt only when control bit 4 (SMI on sleep write) is set.
- R6: The SMBus slave message and alert pulses set status bit N_TRAP+2 (bit 6). Host notify sets bit N_TRAP+3 (bit 7). These causes raise only an SMI, never an SCI. All of them need control bit 6 (SMBus SMI enable), and host notify also needs control bit 7.
- R7: A `mc_acc_evt` pulse sets status bit N_TRAP+1 (bit 5). It raises an interrupt only when control bit 5 is set.
- R8: Status bits are sticky. Writing 1 to a bit of register 2 clears it, and writing 0 has no effect. An event in the same cycle as a clear of its bit leaves the bit set.
- R9: `sci_irq` follows the code in control bits 10:8. Codes 0, 1 and 2 give 9, 10 and 11. Codes 4 to 7 give 20 to 23, but only when control bit 2 (APIC mode) is set. Every other combination gives 9.
- R10: After reset `smi_n` is 1, `sci_req` is 0, `sci_irq` is 9 and all registers read 0. `reg_rdata` shows the addressed register in the same cycle, and the end-of-SMI bit reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 trap enables, 2 status, 3 reserved |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data of the addressed register |
| trap_hit | input | N_TRAP | Per-device address-trap match pulses |
| slp_wr_evt | input | 1 | Sleep-enable bit written with 1 |
| mc_acc_evt | input | 1 | Microcontroller port access |
| smb_slave_evt | input | 1 | SMBus slave SMI message received |
| smb_alert_evt | input | 1 | SMBus alert signal active |
| smb_hn_evt | input | 1 | SMBus host-notify message received |
| smi_n | output | 1 | System management interrupt, active low |
| sci_req | output | 1 | System control interrupt request level |
| sci_irq | output | 5 | Interrupt number chosen for the SCI |

## Verification
Each status bit is due one clock edge after its event pulse, and `sci_req` follows it in that same cycle. `smi_n` falls one edge later still. After an end-of-SMI write it is high for exactly one cycle when a cause is still pending. `sci_irq` and `reg_rdata` are combinational from the registers, so they change in the cycle right after a write. A behavioural model in the bench steps on the same clock edge and is compared with every output one nanosecond after that edge. Inputs are driven on the falling edge, so each result is checked in the very cycle it is due, and each directed check sits a fixed number of edges after its stimulus.

// File: rtl/pmr_pkg.sv
package pmr_pkg;

  // control word bit positions
  localparam int unsigned CTL_ROUTE    = 0;
  localparam int unsigned CTL_GBL      = 1;
  localparam int unsigned CTL_APIC     = 2;
  localparam int unsigned CTL_EOS      = 3;
  localparam int unsigned CTL_SLP      = 4;
  localparam int unsigned CTL_MC       = 5;
  localparam int unsigned CTL_SMB      = 6;
  localparam int unsigned CTL_HN       = 7;
  localparam int unsigned CTL_CODE_LSB = 8;
  localparam int unsigned CODE_W       = 3;
  localparam int unsigned CTL_USED     = CTL_CODE_LSB + CODE_W;
  localparam int unsigned IRQ_W        = 5;

  typedef enum logic [1:0] {
    ADDR_CTRL    = 2'd0,
    ADDR_TRAP_EN = 2'd1,
    ADDR_STS     = 2'd2,
    ADDR_RSVD    = 2'd3
  } pmr_addr_e;

  typedef struct packed {
    logic              route_sci;
    logic              gbl_smi;
    logic              apic;
    logic              slp_smi_en;
    logic              mc_en;
    logic              smb_en;
    logic              hn_en;
    logic [CODE_W-1:0] code;
  } pmr_ctrl_t;

  // interrupt number chosen for the SCI
  function automatic logic [IRQ_W-1:0] pmr_irq_of(input logic [CODE_W-1:0] code,
                                                  input logic apic);
    logic [IRQ_W-1:0] irq;
    if (code < 3'd3)
      irq = 5'd9 + {2'b00, code};
    else if (code[2] && apic)
      irq = 5'd16 + {2'b00, code};
    else
      irq = 5'd9;
    return irq;
  endfunction

endpackage

// File: rtl/pmr_cfg_regs.sv
module pmr_cfg_regs
  import pmr_pkg::*;
#(
  parameter int unsigned DW     = 16,
  parameter int unsigned N_TRAP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_trap,
  input  logic [DW-1:0]     wdata,
  output pmr_ctrl_t         ctrl,
  output logic [N_TRAP-1:0] trap_en,
  output logic              eos_pulse
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (wr_ctrl) begin
      ctrl.route_sci  <= wdata[CTL_ROUTE];
      ctrl.gbl_smi    <= wdata[CTL_GBL];
      ctrl.apic       <= wdata[CTL_APIC];
      ctrl.slp_smi_en <= wdata[CTL_SLP];
      ctrl.mc_en      <= wdata[CTL_MC];
      ctrl.smb_en     <= wdata[CTL_SMB];
      ctrl.hn_en      <= wdata[CTL_HN];
      ctrl.code       <= wdata[CTL_CODE_LSB +: CODE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      trap_en <= '0;
    else if (wr_trap)
      trap_en <= wdata[N_TRAP-1:0];
  end

  // end-of-SMI is a strobe, never stored
  assign eos_pulse = wr_ctrl & wdata[CTL_EOS];

endmodule

// File: rtl/pmr_status_bank.sv
module pmr_status_bank #(
  parameter int unsigned NB = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] set_vec,
  input  logic [NB-1:0] clr_vec,
  output logic [NB-1:0] sts
);

  for (genvar b = 0; b < NB; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sts[b] <= 1'b0;
      else if (set_vec[b])
        sts[b] <= 1'b1;           // a new event beats a clear
      else if (clr_vec[b])
        sts[b] <= 1'b0;
    end

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sts[b] && !clr_vec[b] |=> sts[b]);
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[b] |=> sts[b]);
  end

endmodule

// File: rtl/pmr_smi_lock.sv
module pmr_smi_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic smi_cause,
  input  logic eos,
  input  logic gbl_en,
  input  logic route_sci,
  output logic smi_act
);

  logic smi_act_d;

  // once raised, only end-of-SMI releases the line; new causes wait
  always_comb begin
    if (smi_act)
      smi_act_d = !eos;
    else
      smi_act_d = smi_cause;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      smi_act <= 1'b0;
    else
      smi_act <= smi_act_d;
  end

  p_hold_until_eos_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smi_act && !eos |=> smi_act);
  p_release_on_eos_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smi_act && eos |=> !smi_act);
  p_gbl_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smi_act) |-> $past(gbl_en));
  p_route_smi_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smi_act) |-> !$past(route_sci));

endmodule

// File: rtl/pm_event_router.sv
module pm_event_router
  import pmr_pkg::*;
#(
  parameter int unsigned DW     = 16,
  parameter int unsigned N_TRAP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [N_TRAP-1:0] trap_hit,
  input  logic              slp_wr_evt,
  input  logic              mc_acc_evt,
  input  logic              smb_slave_evt,
  input  logic              smb_alert_evt,
  input  logic              smb_hn_evt,
  output logic              smi_n,
  output logic              sci_req,
  output logic [IRQ_W-1:0]  sci_irq
);

  localparam int unsigned NB    = N_TRAP + 4;
  localparam int unsigned I_SLP = N_TRAP;
  localparam int unsigned I_MC  = N_TRAP + 1;
  localparam int unsigned I_SMB = N_TRAP + 2;
  localparam int unsigned I_HN  = N_TRAP + 3;
  // causes that may be steered to the SCI
  localparam logic [NB-1:0] SCI_CAPABLE = {2'b00, {(N_TRAP + 2){1'b1}}};

  pmr_ctrl_t         ctrl;
  logic [N_TRAP-1:0] trap_en;
  logic              eos_pulse;
  logic              wr_ctrl, wr_trap, wr_sts;
  logic [NB-1:0]     set_vec, clr_vec, sts, en_mask, pend;
  logic              sci_pend, smi_cause, smi_act;

  assign wr_ctrl = reg_wr && (pmr_addr_e'(reg_addr) == ADDR_CTRL);
  assign wr_trap = reg_wr && (pmr_addr_e'(reg_addr) == ADDR_TRAP_EN);
  assign wr_sts  = reg_wr && (pmr_addr_e'(reg_addr) == ADDR_STS);

  pmr_cfg_regs #(.DW(DW), .N_TRAP(N_TRAP)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctrl  (wr_ctrl),
    .wr_trap  (wr_trap),
    .wdata    (reg_wdata),
    .ctrl     (ctrl),
    .trap_en  (trap_en),
    .eos_pulse(eos_pulse)
  );

  assign set_vec = {smb_hn_evt, smb_slave_evt | smb_alert_evt, mc_acc_evt, slp_wr_evt, trap_hit};
  assign clr_vec = wr_sts ? reg_wdata[NB-1:0] : '0;

  pmr_status_bank #(.NB(NB)) u_sts (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec(set_vec),
    .clr_vec(clr_vec),
    .sts    (sts)
  );

  assign en_mask = {ctrl.smb_en & ctrl.hn_en, ctrl.smb_en, ctrl.mc_en, ctrl.slp_smi_en, trap_en};
  assign pend      = sts & en_mask;
  assign sci_pend  = |(pend & SCI_CAPABLE);
  assign sci_req   = ctrl.route_sci & sci_pend;
  assign smi_cause = !ctrl.route_sci && ctrl.gbl_smi && (|pend);

  pmr_smi_lock u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .smi_cause(smi_cause),
    .eos      (eos_pulse),
    .gbl_en   (ctrl.gbl_smi),
    .route_sci(ctrl.route_sci),
    .smi_act  (smi_act)
  );

  assign smi_n   = !smi_act;
  assign sci_irq = pmr_irq_of(ctrl.code, ctrl.apic);

  always_comb begin
    reg_rdata = '0;
    unique case (pmr_addr_e'(reg_addr))
      ADDR_CTRL: begin
        reg_rdata[CTL_ROUTE] = ctrl.route_sci;
        reg_rdata[CTL_GBL]   = ctrl.gbl_smi;
        reg_rdata[CTL_APIC]  = ctrl.apic;
        reg_rdata[CTL_SLP]   = ctrl.slp_smi_en;
        reg_rdata[CTL_MC]    = ctrl.mc_en;
        reg_rdata[CTL_SMB]   = ctrl.smb_en;
        reg_rdata[CTL_HN]    = ctrl.hn_en;
        reg_rdata[CTL_CODE_LSB +: CODE_W] = ctrl.code;
      end
      ADDR_TRAP_EN: reg_rdata[N_TRAP-1:0] = trap_en;
      ADDR_STS:     reg_rdata[NB-1:0]     = sts;
      default:      reg_rdata = '0;
    endcase
  end

  p_trap_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_hit[0] |=> reg_rdata[0] || (pmr_addr_e'(reg_addr) != ADDR_STS));
  p_smb_never_sci_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sci_req |-> |(sts[N_TRAP+1:0]));
  p_sci_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sci_req |-> !$rose(smi_act));
  p_irq_apic_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sci_irq >= 5'd20 |-> ctrl.apic);
  p_hn_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smi_act) && !$past(|pend[I_HN-1:0]) |-> $past(ctrl.hn_en));

endmodule

// File: tb/tb_pm_event_router.sv
module tb_pm_event_router;

  localparam int NT = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = 2'd2;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [NT-1:0] trap_hit = '0;
  logic slp_wr_evt = 0, mc_acc_evt = 0, smb_slave_evt = 0, smb_alert_evt = 0, smb_hn_evt = 0;
  logic smi_n, sci_req;
  logic [4:0] sci_irq;

  int checks = 0, fails = 0;
  bit done = 0, summarised = 0;
  string cur_tag = "R10";

  pm_event_router #(.DW(DW), .N_TRAP(NT)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trap_hit(trap_hit),
    .slp_wr_evt(slp_wr_evt), .mc_acc_evt(mc_acc_evt),
    .smb_slave_evt(smb_slave_evt), .smb_alert_evt(smb_alert_evt),
    .smb_hn_evt(smb_hn_evt), .smi_n(smi_n), .sci_req(sci_req), .sci_irq(sci_irq)
  );

  always #2 clk = ~clk;   // 250 MHz

  // ---------------- behavioural reference model ----------------
  bit m_route, m_gbl, m_apic, m_slp, m_mc, m_smb, m_hn, m_smi;
  int m_code;
  bit m_ten[NT];
  bit m_st[8];            // 0..3 traps, 4 sleep, 5 micro, 6 smbus, 7 host notify

  function automatic int irq_expect(int code, bit apic);
    case (code)
      0: return 9;
      1: return 10;
      2: return 11;
      4, 5, 6, 7: return apic ? code + 16 : 9;
      default: return 9;
    endcase
  endfunction

  function automatic bit enabled(int b);
    if (b < NT) return m_ten[b];
    if (b == 4) return m_slp;
    if (b == 5) return m_mc;
    if (b == 6) return m_smb;
    return m_smb && m_hn;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_route = 0; m_gbl = 0; m_apic = 0; m_slp = 0; m_mc = 0; m_smb = 0; m_hn = 0;
      m_smi = 0; m_code = 0;
      foreach (m_ten[i]) m_ten[i] = 0;
      foreach (m_st[i]) m_st[i] = 0;
    end else begin
      bit any;
      bit eos;
      bit ev[8];
      any = 0;
      for (int b = 0; b < 8; b++) if (m_st[b] && enabled(b)) any = 1;
      eos = reg_wr && reg_addr == 0 && reg_wdata[3];
      if (m_smi) begin
        if (eos) m_smi = 0;
      end else if (!m_route && m_gbl && any) begin
        m_smi = 1;
      end
      if (reg_wr && reg_addr == 0) begin
        m_route = reg_wdata[0]; m_gbl = reg_wdata[1]; m_apic = reg_wdata[2];
        m_slp = reg_wdata[4]; m_mc = reg_wdata[5]; m_smb = reg_wdata[6];
        m_hn = reg_wdata[7]; m_code = int'(reg_wdata[10:8]);
      end
      if (reg_wr && reg_addr == 1)
        for (int i = 0; i < NT; i++) m_ten[i] = reg_wdata[i];
      for (int i = 0; i < NT; i++) ev[i] = trap_hit[i];
      ev[4] = slp_wr_evt; ev[5] = mc_acc_evt;
      ev[6] = smb_slave_evt | smb_alert_evt; ev[7] = smb_hn_evt;
      for (int b = 0; b < 8; b++) begin
        if (reg_wr && reg_addr == 2 && reg_wdata[b]) m_st[b] = 0;
        if (ev[b]) m_st[b] = 1;
      end
    end
  end

  function automatic logic [DW-1:0] model_read(logic [1:0] a);
    logic [DW-1:0] v;
    v = '0;
    if (a == 0) begin
      v[0] = m_route; v[1] = m_gbl; v[2] = m_apic; v[4] = m_slp;
      v[5] = m_mc; v[6] = m_smb; v[7] = m_hn; v[10:8] = 3'(m_code);
    end else if (a == 1) begin
      for (int i = 0; i < NT; i++) v[i] = m_ten[i];
    end else if (a == 2) begin
      for (int b = 0; b < 8; b++) v[b] = m_st[b];
    end
    return v;
  endfunction

  function automatic bit model_sci();
    bit s;
    s = 0;
    for (int b = 0; b < 6; b++) if (m_st[b] && enabled(b)) s = 1;
    return m_route && s;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare every cycle, 1 ns after the active edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(cur_tag, "smi_n", int'(smi_n), int'(!m_smi));
      chk(cur_tag, "sci_req", int'(sci_req), int'(model_sci()));
      chk(cur_tag, "sci_irq", int'(sci_irq), irq_expect(m_code, m_apic));
      chk(cur_tag, "reg_rdata", int'(reg_rdata), int'(model_read(reg_addr)));
    end
  end

  // ---------------- stimulus helpers ----------------
  logic [DW-1:0] cfg;

  function automatic logic [DW-1:0] cw(bit route, bit gbl, bit apic, bit slp, bit mc,
                                       bit smb, bit hn, int code);
    logic [DW-1:0] v;
    v = '0;
    v[0] = route; v[1] = gbl; v[2] = apic; v[4] = slp; v[5] = mc; v[6] = smb; v[7] = hn;
    v[10:8] = 3'(code);
    return v;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_addr = 2'd2; reg_wdata = '0;
  endtask

  task automatic set_cfg(input logic [DW-1:0] d);
    cfg = d; wr(2'd0, d);
  endtask

  task automatic eos(); wr(2'd0, cfg | 16'h0008); endtask

  task automatic ev(input logic [NT-1:0] t, bit s, bit m, bit sl, bit al, bit hn);
    @(negedge clk);
    trap_hit = t; slp_wr_evt = s; mc_acc_evt = m;
    smb_slave_evt = sl; smb_alert_evt = al; smb_hn_evt = hn;
    @(negedge clk);
    trap_hit = '0; slp_wr_evt = 0; mc_acc_evt = 0;
    smb_slave_evt = 0; smb_alert_evt = 0; smb_hn_evt = 0;
  endtask

  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  task automatic summary();
    if (!summarised) begin
      summarised = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      done = 1;
      summary();
    end
  end

  initial begin
    cfg = '0;
    idle(3);
    // R10: reset values
    cur_tag = "R10";
    chk("R10", "smi_n reset", int'(smi_n), 1);
    chk("R10", "sci_req reset", int'(sci_req), 0);
    chk("R10", "sci_irq reset", int'(sci_irq), 9);
    chk("R10", "status reset", int'(reg_rdata), 0);
    rst_n = 1;
    idle(2);

    // R4: trap status always set, interrupt only with enable
    cur_tag = "R4";
    set_cfg(cw(0, 1, 0, 0, 0, 0, 0, 0));
    wr(2'd1, 16'h0002);
    ev(4'b0011, 0, 0, 0, 0, 0);
    idle(2);
    chk("R4", "trap smi_n", int'(smi_n), 0);
    chk("R4", "trap status", int'(reg_rdata), 3);

    // R3: lock-out and end-of-SMI
    cur_tag = "R3";
    ev(4'b0010, 0, 0, 0, 0, 0);
    idle(2);
    chk("R3", "locked smi_n", int'(smi_n), 0);
    wr(2'd2, 16'h0003);
    eos();
    idle(2);
    chk("R3", "released smi_n", int'(smi_n), 1);
    ev(4'b0010, 0, 0, 0, 0, 0);
    idle(2);
    eos();
    chk("R3", "gap after eos", int'(smi_n), 1);
    idle(1);
    chk("R3", "reassert", int'(smi_n), 0);

    // R8: write-1-to-clear, zero writes, set beats clear
    cur_tag = "R8";
    wr(2'd2, 16'h0000);
    chk("R8", "zero write", int'(reg_rdata), 2);
    @(negedge clk);
    reg_wr = 1; reg_addr = 2'd2; reg_wdata = 16'h0002; trap_hit = 4'b0010;
    @(negedge clk);
    reg_wr = 0; reg_wdata = '0; trap_hit = '0;
    chk("R8", "set wins", int'(reg_rdata), 2);
    wr(2'd2, 16'h00FF);
    chk("R8", "clear all", int'(reg_rdata), 0);
    eos();

    // R2: global SMI enable
    cur_tag = "R2";
    set_cfg(cw(0, 0, 0, 0, 0, 0, 0, 0));
    ev(4'b0010, 0, 0, 0, 0, 0);
    idle(2);
    chk("R2", "gated smi_n", int'(smi_n), 1);
    set_cfg(cw(0, 1, 0, 0, 0, 0, 0, 0));
    idle(1);
    chk("R2", "late enable smi_n", int'(smi_n), 0);
    wr(2'd2, 16'h00FF);
    eos();

    // R1: SCI routing
    cur_tag = "R1";
    set_cfg(cw(1, 1, 0, 0, 0, 0, 0, 1));
    ev(4'b0010, 0, 0, 0, 0, 0);
    chk("R1", "sci same cycle", int'(sci_req), 1);
    idle(2);
    chk("R1", "no smi on sci route", int'(smi_n), 1);
    wr(2'd2, 16'h0002);
    chk("R1", "sci drops", int'(sci_req), 0);

    // R9: interrupt number map
    cur_tag = "R9";
    for (int a = 0; a < 2; a++)
      for (int c = 0; c < 8; c++) begin
        set_cfg(cw(1, 1, bit'(a), 0, 0, 0, 0, c));
        chk("R9", "irq map", int'(sci_irq), irq_expect(c, bit'(a)));
      end

    // R5: sleep-enable writes
    cur_tag = "R5";
    set_cfg(cw(0, 1, 0, 0, 0, 0, 0, 0));
    ev('0, 1, 0, 0, 0, 0);
    idle(2);
    chk("R5", "sleep no enable", int'(smi_n), 1);
    chk("R5", "sleep status", int'(reg_rdata), 16);
    wr(2'd2, 16'h0010);
    set_cfg(cw(0, 1, 0, 1, 0, 0, 0, 0));
    ev('0, 1, 0, 0, 0, 0);
    idle(2);
    chk("R5", "sleep smi", int'(smi_n), 0);
    wr(2'd2, 16'h00FF);
    eos();

    // R7: microcontroller accesses
    cur_tag = "R7";
    set_cfg(cw(1, 1, 0, 0, 1, 0, 0, 2));
    ev('0, 0, 1, 0, 0, 0);
    chk("R7", "micro sci", int'(sci_req), 1);
    chk("R7", "micro status", int'(reg_rdata), 32);
    wr(2'd2, 16'h0020);
    set_cfg(cw(0, 1, 0, 0, 1, 0, 0, 2));
    ev('0, 0, 1, 0, 0, 0);
    idle(2);
    chk("R7", "micro smi", int'(smi_n), 0);
    wr(2'd2, 16'h00FF);
    eos();

    // R6: SMBus causes are SMI-only
    cur_tag = "R6";
    set_cfg(cw(0, 1, 0, 0, 0, 1, 0, 0));
    ev('0, 0, 0, 0, 1, 0);
    idle(2);
    chk("R6", "alert smi", int'(smi_n), 0);
    chk("R6", "alert status", int'(reg_rdata), 64);
    wr(2'd2, 16'h00FF);
    eos();
    ev('0, 0, 0, 0, 0, 1);
    idle(2);
    chk("R6", "notify needs own enable", int'(smi_n), 1);
    chk("R6", "notify status", int'(reg_rdata), 128);
    wr(2'd2, 16'h00FF);
    set_cfg(cw(1, 1, 0, 0, 0, 1, 1, 0));
    ev('0, 0, 0, 1, 0, 1);
    idle(2);
    chk("R6", "smbus never sci", int'(sci_req), 0);
    chk("R6", "smbus no smi on sci route", int'(smi_n), 1);
    wr(2'd2, 16'h00FF);
    idle(3);

    done = 1;
    summary();
  end

endmodule